// File: doc/BRIEF.md
# Sector-to-memory DMA engine

The engine copies one storage sector into system memory with no processor involvement in the data movement. Software programs it through four word-wide register slots. It writes a logical block number and a destination address, then writes a read command. The engine then fetches the sector one word at a time from a storage-side read port. It writes each word to memory over a request/acknowledge bus, placing the words at consecutive word addresses that start at the programmed destination.

After the memory acknowledges the last word, the engine goes idle and raises its interrupt output. The interrupt stays high until software writes a clear bit in the status slot. Command values other than the read opcode do not start a transfer; they set an error flag instead. While a transfer runs, software writes to the command, block number and destination slots are dropped.

Top module: `sector_dma`

## Requirements
- R1: After reset the status slot reads zero, `irq_o` is low, and neither `stor_rd_o` nor `mem_req_o` is asserted.
- R2: A write to slot 0 while idle starts a transfer only when `reg_wdata_i[7:0]` is 8'h01; busy (status bit 0) then reads 1. Any other low byte starts nothing and sets the error flag (status bit 2).
- R3: A transfer requests storage words 0 to SECTOR_WORDS-1 in order, each with the programmed block number on `stor_lba_o`. Word i is written to memory at the destination plus 4*i, and exactly SECTOR_WORDS memory writes occur.
- R4: While `mem_req_o` is high and `mem_ack_i` is low, the request, `mem_addr_o` and `mem_wdata_o` hold their values into the next cycle, for any number of wait states.
- R5: `irq_o` and status bit 1 rise on the same clock edge at which busy falls, and that edge is the acknowledge of the last word.
- R6: `irq_o` stays high until a write to slot 3 with bit 1 set. A status write with bit 1 clear leaves `irq_o` unchanged. A status write with bit 2 set clears the error flag.
- R7: While busy, writes to slots 0, 1 and 2 are ignored. They do not change the running transfer, the readback values or the error flag.
- R8: Slot 1 reads back the block number, slot 2 reads back the destination address, and slot 3 reads back busy in bit 0, interrupt pending in bit 1 and error in bit 2.
- R9: `stor_rd_o` and `mem_req_o` are never high in the same cycle, and both stay low while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register slot select |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for the selected slot |
| stor_rd_o | output | 1 | Storage word request, held until valid |
| stor_lba_o | output | LBA_W | Block number of the transfer |
| stor_idx_o | output | clog2(SECTOR_WORDS) | Word index within the sector |
| stor_valid_i | input | 1 | Storage data valid |
| stor_data_i | input | DATA_W | Storage word |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | Memory write acknowledge |
| irq_o | output | 1 | Transfer-complete interrupt |

## Verification
The bench builds the engine with SECTOR_WORDS set to 16, so each sector is short. With that size, many full transfers fit in the run, with random storage latency and random memory wait states. Several random block numbers and destinations are covered, including one whose last word lands at the top of the address space. Short sectors also leave time to overlap register pokes with a running transfer, to try bad opcodes and to test both clear bits between transfers.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_LBA  = 2'd1;
  localparam logic [1:0] RA_DST  = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  localparam logic [7:0] OP_READ = 8'h01;

  localparam int ST_BUSY = 0;
  localparam int ST_IRQ  = 1;
  localparam int ST_ERR  = 2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_STORE} sq_state_e;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int LBA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              start_o,
  output logic [LBA_W-1:0]  lba_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic              irq_o
);
  logic [LBA_W-1:0]  lba_q;
  logic [ADDR_W-1:0] dst_q;
  logic              irq_q, err_q;
  logic              wr_cmd, wr_lba, wr_dst, wr_stat, op_ok;

  // slots 0..2 are locked while a transfer runs
  assign wr_cmd  = reg_wr_i && (reg_addr_i == RA_CMD) && !busy_i;
  assign wr_lba  = reg_wr_i && (reg_addr_i == RA_LBA) && !busy_i;
  assign wr_dst  = reg_wr_i && (reg_addr_i == RA_DST) && !busy_i;
  assign wr_stat = reg_wr_i && (reg_addr_i == RA_STAT);
  assign op_ok   = (reg_wdata_i[7:0] == OP_READ);
  assign start_o = wr_cmd && op_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lba_q <= '0;
      dst_q <= '0;
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (wr_lba) lba_q <= reg_wdata_i[LBA_W-1:0];
      if (wr_dst) dst_q <= reg_wdata_i[ADDR_W-1:0];
      if (wr_cmd && !op_ok)                err_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[ST_ERR]) err_q <= 1'b0;
      if (done_i)                          irq_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[ST_IRQ]) irq_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_LBA:  reg_rdata_o = DATA_W'(lba_q);
      RA_DST:  reg_rdata_o = DATA_W'(dst_q);
      RA_STAT: begin
        reg_rdata_o[ST_BUSY] = busy_i;
        reg_rdata_o[ST_IRQ]  = irq_q;
        reg_rdata_o[ST_ERR]  = err_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign lba_o = lba_q;
  assign dst_o = dst_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 32,
  parameter int LBA_W        = 32,
  parameter int SECTOR_WORDS = 128,
  localparam int IDX_W       = $clog2(SECTOR_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic [ADDR_W-1:0] dst_i,
  output logic              stor_rd_o,
  output logic [LBA_W-1:0]  stor_lba_o,
  output logic [IDX_W-1:0]  stor_idx_o,
  input  logic              stor_valid_i,
  input  logic [DATA_W-1:0] stor_data_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);
  localparam logic [IDX_W-1:0]  LAST = IDX_W'(SECTOR_WORDS - 1);

  sq_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LBA_W-1:0]  lba_q;
  logic [DATA_W-1:0] data_q;
  logic              last_w;

  assign last_w = (idx_q == LAST);
  assign done_o = (state_q == SQ_STORE) && mem_ack_i && last_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      lba_q   <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start_i) begin
          state_q <= SQ_FETCH;
          idx_q   <= '0;
          addr_q  <= dst_i;
          lba_q   <= lba_i;
        end
        SQ_FETCH: if (stor_valid_i) begin
          data_q  <= stor_data_i;
          state_q <= SQ_STORE;
        end
        SQ_STORE: if (mem_ack_i) begin
          if (last_w) begin
            state_q <= SQ_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            addr_q  <= addr_q + STEP;
            state_q <= SQ_FETCH;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != SQ_IDLE);
  assign stor_rd_o   = (state_q == SQ_FETCH);
  assign stor_lba_o  = lba_q;
  assign stor_idx_o  = idx_q;
  assign mem_req_o   = (state_q == SQ_STORE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
endmodule

// File: rtl/sector_dma.sv
module sector_dma
  import sdma_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 32,
  parameter int LBA_W        = 32,
  parameter int SECTOR_WORDS = 128
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            reg_wr_i,
  input  logic [1:0]                      reg_addr_i,
  input  logic [DATA_W-1:0]               reg_wdata_i,
  output logic [DATA_W-1:0]               reg_rdata_o,
  output logic                            stor_rd_o,
  output logic [LBA_W-1:0]                stor_lba_o,
  output logic [$clog2(SECTOR_WORDS)-1:0] stor_idx_o,
  input  logic                            stor_valid_i,
  input  logic [DATA_W-1:0]               stor_data_i,
  output logic                            mem_req_o,
  output logic [ADDR_W-1:0]               mem_addr_o,
  output logic [DATA_W-1:0]               mem_wdata_o,
  input  logic                            mem_ack_i,
  output logic                            irq_o
);
  logic              busy, done, start;
  logic [LBA_W-1:0]  lba;
  logic [ADDR_W-1:0] dst;

  sdma_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LBA_W(LBA_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .busy_i      (busy),
    .done_i      (done),
    .start_o     (start),
    .lba_o       (lba),
    .dst_o       (dst),
    .irq_o       (irq_o)
  );

  sdma_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LBA_W(LBA_W), .SECTOR_WORDS(SECTOR_WORDS)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .lba_i        (lba),
    .dst_i        (dst),
    .stor_rd_o    (stor_rd_o),
    .stor_lba_o   (stor_lba_o),
    .stor_idx_o   (stor_idx_o),
    .stor_valid_i (stor_valid_i),
    .stor_data_i  (stor_data_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .busy_o       (busy),
    .done_o       (done)
  );
endmodule

// File: rtl/sector_dma_chk.sv
module sector_dma_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stor_rd_i,
  input logic              mem_req_i,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [DATA_W-1:0] mem_wdata_i,
  input logic              irq_i,
  input logic              irq_clr_i,
  input logic              busy_i
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (!busy_i) begin
      have_prev <= 1'b0;
    end else if (mem_req_i && mem_ack_i) begin
      have_prev <= 1'b1;
      prev_addr <= mem_addr_i;
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_ack_i |=> mem_req_i && $stable(mem_addr_i) && $stable(mem_wdata_i));

  // R9
  one_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stor_rd_i && mem_req_i));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !stor_rd_i && !mem_req_i);

  // R6
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && !irq_clr_i |=> irq_i);

  // R5
  irq_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $fell(busy_i));

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_i) && have_prev |-> mem_addr_i == prev_addr + STEP);
endmodule

bind sector_dma sector_dma_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stor_rd_i   (stor_rd_o),
  .mem_req_i   (mem_req_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_i  (mem_addr_o),
  .mem_wdata_i (mem_wdata_o),
  .irq_i       (irq_o),
  .irq_clr_i   (reg_wr_i && (reg_addr_i == 2'd3) && reg_wdata_i[1]),
  .busy_i      (busy)
);

// File: tb/test_sector_dma.sv
`timescale 1ns/1ps
module test_sector_dma;
  localparam int DW = 32, AW = 32, LW = 32, NW = 16, IW = $clog2(NW);

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic          stor_rd, stor_valid = 1'b0;
  logic [LW-1:0] stor_lba;
  logic [IW-1:0] stor_idx;
  logic [DW-1:0] stor_data = '0;
  logic          mem_req, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          irq;

  sector_dma #(.DATA_W(DW), .ADDR_W(AW), .LBA_W(LW), .SECTOR_WORDS(NW)) i_sector_dma (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .stor_rd_o(stor_rd),
    .stor_lba_o(stor_lba), .stor_idx_o(stor_idx), .stor_valid_i(stor_valid),
    .stor_data_i(stor_data), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [DW-1:0] mem_model [logic [AW-1:0]];
  int wr_cnt = 0, exp_idx = 0, order_err = 0, lba_err = 0, hold_err = 0, both_err = 0;
  int req_seen = 0;
  logic [LW-1:0] cur_lba = '0;
  logic prev_pend = 1'b0;
  logic [AW-1:0] pa;
  logic [DW-1:0] pd;

  function automatic logic [DW-1:0] pattern(logic [LW-1:0] lba, int idx);
    return (lba * 32'h9E37_79B1) ^ {idx[15:0], 16'h5A5A} ^ 32'(idx);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // storage and memory environment
  always @(negedge clk) begin
    if (stor_rd && $urandom_range(0, 3) == 0) begin
      stor_valid = 1'b1;
      stor_data  = pattern(stor_lba, int'(stor_idx));
    end else begin
      stor_valid = 1'b0;
    end
    mem_ack = mem_req && ($urandom_range(0, 2) == 0);
  end

  always @(posedge clk) begin
    if (mem_req) req_seen++;
    if (mem_req && mem_ack) begin
      mem_model[mem_addr] = mem_wdata;
      wr_cnt++;
    end
    if (stor_rd && stor_valid) begin
      if (int'(stor_idx) != exp_idx) order_err++;
      if (stor_lba != cur_lba) lba_err++;
      exp_idx++;
    end
    if (prev_pend && (!mem_req || mem_addr != pa || mem_wdata != pd)) hold_err++;
    prev_pend = mem_req && !mem_ack;
    pa = mem_addr;
    pd = mem_wdata;
    if (stor_rd && mem_req) both_err++;
  end

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq();
    int cyc = 0;
    while (!irq && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_xfer(logic [LW-1:0] lba, logic [AW-1:0] dst, bit poke);
    logic [31:0] d;
    mem_model.delete();
    wr_cnt = 0; exp_idx = 0; cur_lba = lba;
    reg_write(2'd1, lba);
    reg_write(2'd2, dst);
    reg_write(2'd0, 32'h0000_0001);
    reg_read(2'd3, d);
    chk("R2", "busy after start", {31'd0, d[0]}, 32'd1);
    if (poke) begin
      reg_write(2'd1, ~lba);
      reg_write(2'd2, dst + 32'h100);
      reg_write(2'd0, 32'h0000_0007);
      reg_write(2'd0, 32'h0000_0001);
    end
    wait_irq();
    chk("R5", "irq after transfer", {31'd0, irq}, 32'd1);
    reg_read(2'd3, d);
    chk("R5", "status after transfer", {29'd0, d[2:0]}, 32'b010);
    chk("R3", "write count", wr_cnt, NW);
    chk("R3", "storage index order errors", order_err, 0);
    chk("R3", "storage block number errors", lba_err, 0);
    for (int i = 0; i < NW; i++) begin
      logic [AW-1:0] a;
      a = dst + AW'(4 * i);
      chk("R3", $sformatf("word %0d", i),
          mem_model.exists(a) ? mem_model[a] : 32'hDEAD_BEEF, pattern(lba, i));
    end
    if (poke) begin
      reg_read(2'd1, d);
      chk("R7", "block number unchanged", d, lba);
      reg_read(2'd2, d);
      chk("R7", "destination unchanged", d, dst);
    end
    reg_write(2'd3, 32'h0000_0000);
    chk("R6", "irq kept on status write without clear bit", {31'd0, irq}, 32'd1);
    reg_write(2'd3, 32'h0000_0002);
    chk("R6", "irq cleared", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(2'd3, d);
    chk("R1", "status after reset", d, 32'd0);
    chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
    chk("R1", "requests after reset", {30'd0, stor_rd, mem_req}, 32'd0);

    reg_write(2'd1, 32'hCAFE_0123);
    reg_read(2'd1, d);
    chk("R8", "block number readback", d, 32'hCAFE_0123);
    reg_write(2'd2, 32'h0004_1000);
    reg_read(2'd2, d);
    chk("R8", "destination readback", d, 32'h0004_1000);

    req_seen = 0;
    reg_write(2'd0, 32'h0000_0002);
    reg_read(2'd3, d);
    chk("R2", "bad opcode status", {29'd0, d[2:0]}, 32'b100);
    reg_write(2'd0, 32'hFFFF_FF00);
    repeat (20) @(negedge clk);
    chk("R2", "no memory requests after bad opcodes", req_seen, 0);
    chk("R2", "no irq after bad opcodes", {31'd0, irq}, 32'd0);
    reg_write(2'd3, 32'h0000_0004);
    reg_read(2'd3, d);
    chk("R6", "error flag cleared", d, 32'd0);

    run_xfer(32'h0000_0000, 32'h0000_0000, 1'b0);
    run_xfer(32'hFFFF_FFFF, 32'hFFFF_FFC0, 1'b0);
    run_xfer(32'h1234_5678, 32'h0010_0000, 1'b1);
    reg_read(2'd3, d);
    chk("R7", "no error from command write while busy", {31'd0, d[2]}, 32'd0);
    for (int k = 0; k < 5; k++)
      run_xfer($urandom(), $urandom() & 32'hFFFF_FFFC, k[0]);

    chk("R4", "request hold violations", hold_err, 0);
    chk("R9", "storage and memory requested together", both_err, 0);
    @(negedge clk);
    chk("R9", "idle outputs quiet", {30'd0, stor_rd, mem_req}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule